// File: doc/BRIEF.md
# Vectored interrupt priority resolver

This block keeps the interrupt state of one processor core across a space of 256 vectors. It holds three 256-bit vectors: pending requests, requests in service, and the trigger mode of each request. It also holds a task-priority byte and a 9-bit spurious/enable register. From the highest in-service vector and the task priority it derives a processor-priority byte. The number of a vector is its priority. Vectors fall into classes of 16, and the class is the upper nibble of the vector number.

Interrupt sources post vectors through a set port. The core watches a pending line and fetches a vector through a one-cycle acknowledge request. The reply arrives on the next cycle and carries a real vector, the spurious vector, or a "nothing pending" flag. The core retires the most urgent in-service vector with an end-of-interrupt strobe.

Top module: `vec_prio_resolver`

## Requirements
- R1: After reset all three vector registers are empty, the task priority is 0 and the spurious register holds 0x0FF, so bit 8 is clear and the block is disabled. The pending line is low and the processor priority reads 0.
- R2: A higher vector number has a higher priority. An acknowledge serves the highest-numbered pending vector.
- R3: The processor priority equals the task priority when the task priority's upper nibble is greater than or equal to the class of the highest in-service vector. Otherwise it equals that class shifted left by 4. An empty in-service set counts as class 0.
- R4: The pending line is high only when bit 8 of the spurious register is set and at least one request is pending. When the processor priority is nonzero, the class of the highest request must also be strictly greater than the processor priority's upper nibble.
- R5: Posting a vector sets its request bit and records its trigger mode (1 = level, 0 = edge). A later post of the same vector overwrites the mode. A granted acknowledge returns the mode on `ack_level`.
- R6: If the task priority is nonzero and the highest pending vector is less than or equal to it, an acknowledge returns bits 7:0 of the spurious register with `ack_none` = 0. The request and in-service sets are left unchanged.
- R7: In every other case with a request pending, an acknowledge clears that request bit, sets the same bit in service, and returns the vector number.
- R8: An acknowledge with no request pending returns `ack_none` = 1 with vector 0.
- R9: End-of-interrupt clears only the highest in-service bit. It has no effect when the in-service set is empty.
- R10: A spurious-register write stores all 9 bits: bits 7:0 are the spurious vector and bit 8 is the enable.
- R11: `ack_valid` is high exactly one cycle after `ack_req`. The pending line and the processor priority reflect any update in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Post a vector this cycle |
| set_vector | input | 8 | Vector being posted |
| set_level | input | 1 | Trigger mode of the posted vector, 1 = level |
| ack_req | input | 1 | Acknowledge request from the core |
| ack_valid | output | 1 | Acknowledge reply valid |
| ack_vector | output | 8 | Returned vector |
| ack_none | output | 1 | No request was pending |
| ack_level | output | 1 | Trigger mode of a granted vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 8 | Task-priority write data |
| svr_we | input | 1 | Spurious-register write enable |
| svr_wdata | input | 9 | Spurious-register write data |
| irq_pending | output | 1 | Interrupt pending to the core |
| ppr | output | 8 | Processor priority |

## Verification
Requests spread over several classes are served in descending order. Each acknowledge shows the result of the top-down search and the transfer to in-service, and the processor priority exposes the highest in-service class.

A request in the same class as the processor priority but above the task byte separates the vector-level acknowledge test from the class-level pending test. Acknowledging it returns a real vector even though the pending line stayed low. A request at or below the task byte must return the spurious vector, and a later acknowledge must still find that request, which shows it was kept.

Two further cases are covered. Repeated end-of-interrupt strobes, one more than there are in-service vectors, show that each strobe removes only the top vector and that a strobe on an empty set does nothing. Posting the same vector first as level and then as edge shows that the later trigger mode replaces the earlier one.

// File: rtl/vpr_pkg.sv
package vpr_pkg;

   typedef enum logic [1:0] {
      ACK_EMPTY = 2'd0,
      ACK_SPUR  = 2'd1,
      ACK_GRANT = 2'd2
   } ack_kind_t;

endpackage

// File: rtl/vpr_top_finder.sv
module vpr_top_finder #(
   parameter int N         = 256,
   parameter int W         = 32,
   parameter bit TWO_LEVEL = 1'b1,
   localparam int IW = $clog2(N),
   localparam int NW = N / W,
   localparam int WW = $clog2(W)
) (
   input  logic [N-1:0]  bits,
   output logic          any,
   output logic [IW-1:0] idx
);

   if ((N % W) != 0) begin : g_bad_split
      $error("vpr_top_finder: N must be a multiple of W");
   end

   if (TWO_LEVEL) begin : g_two_level
      logic [NW-1:0] word_any;
      logic [WW-1:0] word_idx [NW];

      for (genvar g = 0; g < NW; g++) begin : g_word
         always_comb begin
            word_any[g] = 1'b0;
            word_idx[g] = '0;
            for (int b = 0; b < W; b++) begin
               if (bits[g*W + b]) begin
                  word_any[g] = 1'b1;
                  word_idx[g] = WW'(b);
               end
            end
         end
      end

      always_comb begin
         any = 1'b0;
         idx = '0;
         for (int w = 0; w < NW; w++) begin
            if (word_any[w]) begin
               any = 1'b1;
               idx = IW'(w * W) + IW'(word_idx[w]);
            end
         end
      end
   end else begin : g_flat
      always_comb begin
         any = 1'b0;
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
               any = 1'b1;
               idx = IW'(i);
            end
         end
      end
   end

   always_comb begin
      if (any) begin
         a_r2_top_is_set: assert (bits[idx]);
         a_r2_nothing_above: assert ((bits >> idx) == N'(1));
      end
   end

endmodule

// File: rtl/vpr_prio_calc.sv
module vpr_prio_calc #(
   parameter int VW = 8,
   parameter int CW = 4,
   localparam int LW = VW - CW
) (
   input  logic [VW-1:0] tpr,
   input  logic          isr_any,
   input  logic [VW-1:0] isr_top,
   output logic [VW-1:0] ppr
);

   if (CW < 1 || CW >= VW) begin : g_bad_class
      $error("vpr_prio_calc: class width must be between 1 and VW-1");
   end

   logic [CW-1:0] isr_class;

   always_comb begin
      isr_class = isr_any ? isr_top[VW-1:LW] : '0;
      if (tpr[VW-1:LW] >= isr_class) ppr = tpr;
      else                           ppr = {isr_class, {LW{1'b0}}};
   end

endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
   import vpr_pkg::*;
#(
   parameter int NVEC       = 256,
   parameter int WORD       = 32,
   parameter int CLASS_BITS = 4,
   parameter bit TWO_LEVEL  = 1'b1,
   localparam int VW = $clog2(NVEC),
   localparam int LW = VW - CLASS_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_valid,
   input  logic [VW-1:0] set_vector,
   input  logic          set_level,
   input  logic          ack_req,
   output logic          ack_valid,
   output logic [VW-1:0] ack_vector,
   output logic          ack_none,
   output logic          ack_level,
   input  logic          eoi,
   input  logic          tpr_we,
   input  logic [VW-1:0] tpr_wdata,
   input  logic          svr_we,
   input  logic [VW:0]   svr_wdata,
   output logic          irq_pending,
   output logic [VW-1:0] ppr
);

   if ((NVEC & (NVEC - 1)) != 0) begin : g_bad_nvec
      $error("vec_prio_resolver: NVEC must be a power of two");
   end

   localparam logic [VW:0] SVR_RESET = {1'b0, {VW{1'b1}}};

   logic [NVEC-1:0] irr_q, isr_q, tmr_q;
   logic [NVEC-1:0] irr_n, isr_n, tmr_n;
   logic [VW-1:0]   tpr_q;
   logic [VW:0]     svr_q;
   logic            irr_any, isr_any;
   logic [VW-1:0]   irr_top, isr_top;
   ack_kind_t       kind;
   logic            grant, eoi_do;

   vpr_top_finder #(.N(NVEC), .W(WORD), .TWO_LEVEL(TWO_LEVEL)) u_irr_find (
      .bits(irr_q), .any(irr_any), .idx(irr_top)
   );

   vpr_top_finder #(.N(NVEC), .W(WORD), .TWO_LEVEL(TWO_LEVEL)) u_isr_find (
      .bits(isr_q), .any(isr_any), .idx(isr_top)
   );

   vpr_prio_calc #(.VW(VW), .CW(CLASS_BITS)) u_prio (
      .tpr(tpr_q), .isr_any(isr_any), .isr_top(isr_top), .ppr(ppr)
   );

   always_comb begin
      if (!irr_any)                                kind = ACK_EMPTY;
      else if (tpr_q != '0 && irr_top <= tpr_q)    kind = ACK_SPUR;
      else                                         kind = ACK_GRANT;
   end

   assign grant  = ack_req && (kind == ACK_GRANT);
   assign eoi_do = eoi && isr_any;

   always_comb begin
      irr_n = irr_q;
      isr_n = isr_q;
      tmr_n = tmr_q;
      if (grant)     irr_n[irr_top]    = 1'b0;
      if (set_valid) irr_n[set_vector] = 1'b1;
      if (set_valid) tmr_n[set_vector] = set_level;
      if (eoi_do)    isr_n[isr_top]    = 1'b0;
      if (grant)     isr_n[irr_top]    = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q      <= '0;
         isr_q      <= '0;
         tmr_q      <= '0;
         tpr_q      <= '0;
         svr_q      <= SVR_RESET;
         ack_valid  <= 1'b0;
         ack_vector <= '0;
         ack_none   <= 1'b0;
         ack_level  <= 1'b0;
      end else begin
         irr_q     <= irr_n;
         isr_q     <= isr_n;
         tmr_q     <= tmr_n;
         if (tpr_we) tpr_q <= tpr_wdata;
         if (svr_we) svr_q <= svr_wdata;
         ack_valid <= ack_req;
         if (ack_req) begin
            unique case (kind)
               ACK_EMPTY: begin
                  ack_vector <= '0;
                  ack_none   <= 1'b1;
                  ack_level  <= 1'b0;
               end
               ACK_SPUR: begin
                  ack_vector <= svr_q[VW-1:0];
                  ack_none   <= 1'b0;
                  ack_level  <= 1'b0;
               end
               default: begin
                  ack_vector <= irr_top;
                  ack_none   <= 1'b0;
                  ack_level  <= tmr_q[irr_top];
               end
            endcase
         end
      end
   end

   assign irq_pending = svr_q[VW] && irr_any &&
                        ((ppr == '0) || (irr_top[VW-1:LW] > ppr[VW-1:LW]));

   // R11: reply one cycle after request
   a_r11_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> ack_valid);

   // R4: pending requires the software enable
   a_r4_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |-> svr_q[VW]);

   // R9: a lone end-of-interrupt removes exactly one in-service vector
   a_r9_eoi_single: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack_req && isr_q != '0) |=>
         ($countones(isr_q) == $past($countones(isr_q)) - 1));

   // R8: a "nothing pending" reply means the request set was empty
   a_r8_none_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_none) |-> $past(irr_q == '0));

endmodule

// File: tb/vec_prio_resolver_test.sv
module vec_prio_resolver_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       set_valid = 1'b0;
   logic [7:0] set_vector = '0;
   logic       set_level = 1'b0;
   logic       ack_req = 1'b0;
   logic       ack_valid;
   logic [7:0] ack_vector;
   logic       ack_none;
   logic       ack_level;
   logic       eoi = 1'b0;
   logic       tpr_we = 1'b0;
   logic [7:0] tpr_wdata = '0;
   logic       svr_we = 1'b0;
   logic [8:0] svr_wdata = '0;
   logic       irq_pending;
   logic [7:0] ppr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vec_prio_resolver uut (
      .clk(clk), .rst_n(rst_n),
      .set_valid(set_valid), .set_vector(set_vector), .set_level(set_level),
      .ack_req(ack_req), .ack_valid(ack_valid), .ack_vector(ack_vector),
      .ack_none(ack_none), .ack_level(ack_level),
      .eoi(eoi),
      .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
      .svr_we(svr_we), .svr_wdata(svr_wdata),
      .irq_pending(irq_pending), .ppr(ppr)
   );

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   task automatic post(input logic [7:0] v, input logic lvl);
      @(negedge clk);
      set_valid = 1'b1; set_vector = v; set_level = lvl;
      @(negedge clk);
      set_valid = 1'b0;
   endtask

   task automatic fetch(output logic [7:0] v, output logic none,
                        output logic lvl, output logic vld);
      @(negedge clk);
      ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      v = ack_vector; none = ack_none; lvl = ack_level; vld = ack_valid;
   endtask

   task automatic retire();
      @(negedge clk);
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
   endtask

   task automatic put_tpr(input logic [7:0] d);
      @(negedge clk);
      tpr_we = 1'b1; tpr_wdata = d;
      @(negedge clk);
      tpr_we = 1'b0;
   endtask

   task automatic put_svr(input logic [8:0] d);
      @(negedge clk);
      svr_we = 1'b1; svr_wdata = d;
      @(negedge clk);
      svr_we = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v; logic n, l, vd;
      chk("R1 pending after reset", irq_pending, 0);
      chk("R1 ppr after reset", ppr, 0);
      fetch(v, n, l, vd);
      chk("R11 ack_valid", vd, 1);
      chk("R8 none flag on empty", n, 1);
      chk("R8 vector on empty", v, 0);
      @(negedge clk);
      chk("R11 ack_valid drops", ack_valid, 0);
   endtask

   task automatic t_enable();
      logic [7:0] v; logic n, l, vd;
      post(8'h40, 1'b0);
      chk("R4 R1 disabled at reset keeps pending low", irq_pending, 0);
      put_svr(9'h1F0);
      chk("R4 R10 enable raises pending", irq_pending, 1);
      fetch(v, n, l, vd);
      chk("R7 grant 0x40", v, 8'h40);
      chk("R3 ppr from isr class", ppr, 8'h40);
      retire();
      chk("R9 eoi empties", ppr, 0);
      chk("R4 nothing pending", irq_pending, 0);
   endtask

   task automatic t_order();
      logic [7:0] v; logic n, l, vd;
      post(8'h40, 1'b0);
      post(8'h7E, 1'b1);
      post(8'h41, 1'b0);
      fetch(v, n, l, vd);
      chk("R2 highest first", v, 8'h7E);
      chk("R5 level mode returned", l, 1);
      chk("R3 ppr 0x70", ppr, 8'h70);
      chk("R4 lower class masked", irq_pending, 0);
      fetch(v, n, l, vd);
      chk("R2 next 0x41", v, 8'h41);
      chk("R5 edge mode returned", l, 0);
      retire();
      chk("R9 eoi removes top only", ppr, 8'h40);
      chk("R4 equal class masked", irq_pending, 0);
      retire();
      chk("R9 second eoi", ppr, 0);
      chk("R4 zero ppr lets request through", irq_pending, 1);
      fetch(v, n, l, vd);
      chk("R7 grant 0x40", v, 8'h40);
      retire();
      retire();
      chk("R9 eoi on empty is no-op", ppr, 0);
      fetch(v, n, l, vd);
      chk("R8 empty again", n, 1);
   endtask

   task automatic t_task_prio();
      logic [7:0] v; logic n, l, vd;
      put_tpr(8'h35);
      chk("R3 ppr equals tpr", ppr, 8'h35);
      post(8'h30, 1'b0);
      chk("R4 class not above tpr", irq_pending, 0);
      fetch(v, n, l, vd);
      chk("R6 spurious vector", v, 8'hF0);
      chk("R6 spurious not none", n, 0);
      chk("R6 isr unchanged", ppr, 8'h35);
      post(8'h36, 1'b0);
      chk("R4 same class masked", irq_pending, 0);
      fetch(v, n, l, vd);
      chk("R7 vector above tpr granted", v, 8'h36);
      chk("R3 tpr kept for equal class", ppr, 8'h35);
      put_tpr(8'h25);
      chk("R3 isr class wins", ppr, 8'h30);
      put_tpr(8'h00);
      fetch(v, n, l, vd);
      chk("R6 request kept after spurious", v, 8'h30);
      retire();
      chk("R9 highest 0x36 retired first", ppr, 8'h30);
      retire();
      chk("R9 all retired", ppr, 0);
      put_tpr(8'h35);
      post(8'h40, 1'b0);
      chk("R4 class above tpr raises pending", irq_pending, 1);
      fetch(v, n, l, vd);
      chk("R7 grant 0x40 over tpr", v, 8'h40);
      retire();
      put_tpr(8'h00);
   endtask

   task automatic t_mode_and_svr();
      logic [7:0] v; logic n, l, vd;
      post(8'h90, 1'b1);
      post(8'h90, 1'b0);
      fetch(v, n, l, vd);
      chk("R5 later edge overrides level", l, 0);
      chk("R7 grant 0x90", v, 8'h90);
      retire();
      put_svr(9'h0AB);
      post(8'hA0, 1'b0);
      chk("R4 R10 cleared enable lowers pending", irq_pending, 0);
      put_tpr(8'hF0);
      fetch(v, n, l, vd);
      chk("R10 R6 low byte of spurious register", v, 8'hAB);
      put_tpr(8'h00);
      fetch(v, n, l, vd);
      chk("R7 grant 0xA0", v, 8'hA0);
      retire();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_order();
      t_task_prio();
      t_mode_and_svr();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule